// File: doc/BRIEF.md
# Programmable Multi-Line Delay Store

This block produces the vertical taps of an image window from a stream of pixels. Eight line delays of equal length share one on-chip memory. Every delay has the same run-time programmable length of 1 to `MAX_LEN` pixels. The delays form two groups of four. Group A is always fed from pixel port A. Group B either continues the chain from the end of group A, or takes its own stream from pixel port B. The second case serves interlaced fields or frame-to-frame work. Each accepted pixel beat yields a nine-tap vector: the current A pixel, then the output of every delay, oldest lines last.

The memory is accessed once per accepted beat at a shared circular address. The word is read before the new word is written to the same place. Three things change the taps. A bypass control skips the first delay. A line-restart control (normally driven by composite sync) resets the address pointer. A four-line setting blanks group B. An optional tail output carries the oldest line, so that it can feed a further store. A separate output gives the line-restart input back after a programmable number of clocks.

Pixels enter on a valid/ready stream and leave on a valid/ready stream. Back-pressure works as follows. The input is ready whenever the output register is empty, or is being drained in the same cycle. When the output is stalled, the input is stalled too, and no beat is lost or duplicated.

Top module: `line_delay_store`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `taps_o` and `tail_o` hold their values. `out_valid` falls after a consumed beat when no new beat is accepted.
- R2: A beat accepted at a clock edge appears on the output right after that edge. Tap 0 (`taps_o[7:0]`) equals the beat's `pix_a`.
- R3: The delay length L is the one latched at the latest restart beat. Let n be the number of beats accepted since that restart beat. With `bypass_i`=0, `split_i`=0, `four_i`=0 and `tail_en_i`=0, tap k (`taps_o[8k+7:8k]`, k=1..8) equals `pix_a` of beat n−k·L, whenever n−k·L ≥ 0.
- R4: With `bypass_i`=1, tap 1 equals tap 0. Taps 2..4 equal `pix_a` of beat n−(k−1)·L. In series mode, the chained group-B taps 5..8 equal `pix_a` of beat n−(k−1)·L.
- R5: A beat accepted with `hres_i`=1 is stored at address 0 and becomes beat n=0. `hres_i` on a cycle without an accepted beat does not move the pointer.
- R6: A new `len_i` value takes effect only at the next restart beat. Until then the previous length stays in force.
- R7: With `split_i`=1 and `tail_en_i`=0, taps 5..8 equal `pix_b` of beat n−(k−4)·L.
- R8: With `four_i`=1, taps 5..8 read 0.
- R9: With `tail_en_i`=1, group B is chained to group A whatever `split_i` says. `tail_o` equals the last delay (tap 8 in eight-line mode, tap 4 in four-line mode). With `tail_en_i`=0, `tail_o` is 0.
- R10: `hres_dly_o` equals `hres_i` as it was `hdly_sel_i`+1 clocks earlier.
- R11: The address wraps after L−1. Lengths of 1 and of `MAX_LEN` both follow R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be taken |
| pix_a | input | W | Pixel into group A |
| pix_b | input | W | Pixel into group B when split |
| hres_i | input | 1 | Line restart; resets the pointer on an accepted beat |
| bypass_i | input | 1 | Skip the first delay of group A |
| split_i | input | 1 | 1: group B fed by pix_b; 0: chained |
| four_i | input | 1 | Four-line mode; group-B taps read 0 |
| tail_en_i | input | 1 | Drive tail_o with the last delay; forces chaining |
| len_i | input | LW | Delay length, 1..MAX_LEN, latched on a restart beat |
| hdly_sel_i | input | HS_W | Restart delay select; the delay is hdly_sel_i+1 clocks |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat can be taken |
| taps_o | output | 9*W | Tap k in bits [W*k +: W] |
| tail_o | output | W | Last delay output, or 0 |
| hres_dly_o | output | 1 | Delayed copy of hres_i |

## Verification
The assertions take for granted that `len_i` lies in 1..`MAX_LEN` whenever a restart beat is accepted, and that `hdly_sel_i` stays constant while the delayed restart is observed. They also take for granted that the configuration inputs are sampled only on accepted beats. The stimulus draws lengths only from that range and sets `hdly_sel_i` before each observation window. It changes the mode and length controls only between segments, each segment beginning with a restart beat, except in the one directed case that changes `len_i` on purpose without a restart. Random back-pressure and input gaps come from a fixed seed.

// File: rtl/lds_pkg.sv
package lds_pkg;
  // Group B feed choice
  typedef enum logic {
    GRP_CHAIN = 1'b0,
    GRP_SPLIT = 1'b1
  } grp_mode_e;

  localparam int unsigned GRP_LANES = 4;
  localparam int unsigned ALL_LANES = 2 * GRP_LANES;
  localparam int unsigned TAP_NUM   = ALL_LANES + 1;
endpackage

// File: rtl/lds_ptr.sv
module lds_ptr #(
  parameter int unsigned MAX_LEN = 1024,
  parameter int unsigned AW      = $clog2(MAX_LEN),
  parameter int unsigned LW      = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          hres_i,
  input  logic [LW-1:0] len_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] ptr_q;
  logic [LW-1:0] len_q;
  logic [LW-1:0] eff_len;
  logic [AW-1:0] addr;
  logic          wrap;

  always_comb begin
    eff_len = hres_i ? len_i : len_q;
    addr    = hres_i ? '0 : ptr_q;
    wrap    = (LW'(addr) + LW'(1)) >= eff_len;
  end

  assign addr_o = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      len_q <= LW'(MAX_LEN);
    end else if (step_i) begin
      ptr_q <= wrap ? '0 : addr + AW'(1);
      if (hres_i) len_q <= len_i;
    end
  end

  // R11
  ptr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    LW'(ptr_q) < len_q);

  // R5
  restart_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && hres_i) |=> (ptr_q <= AW'(1)));

  // R5
  idle_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(ptr_q));
endmodule

// File: rtl/lds_ram.sv
module lds_ram #(
  parameter int unsigned DW    = 64,
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  // read of the old word, then write of the new one, at one address
  assign rdata_o = mem[addr_i];

  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end
endmodule

// File: rtl/lds_hdly.sv
module lds_hdly #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned SW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hres_i,
  input  logic [SW-1:0] sel_i,
  output logic          hres_dly_o
);
  logic [DEPTH-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[DEPTH-2:0], hres_i};
  end

  assign hres_dly_o = sr_q[sel_i];

  // R10
  hres_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && sel_i == '0) |-> (hres_dly_o == $past(hres_i)));
endmodule

// File: rtl/line_delay_store.sv
module line_delay_store
  import lds_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned MAX_LEN     = 1024,
  parameter int unsigned HDLY_DEPTH  = 16,
  parameter int unsigned LW          = $clog2(MAX_LEN + 1),
  parameter int unsigned HS_W        = $clog2(HDLY_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [W-1:0]         pix_a,
  input  logic [W-1:0]         pix_b,
  input  logic                 hres_i,
  input  logic                 bypass_i,
  input  logic                 split_i,
  input  logic                 four_i,
  input  logic                 tail_en_i,
  input  logic [LW-1:0]        len_i,
  input  logic [HS_W-1:0]      hdly_sel_i,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [TAP_NUM*W-1:0] taps_o,
  output logic [W-1:0]         tail_o,
  output logic                 hres_dly_o
);
  localparam int unsigned AW = $clog2(MAX_LEN);
  localparam int unsigned DW = ALL_LANES * W;

  logic                 accept;
  logic [AW-1:0]        addr;
  logic [DW-1:0]        wdata, rdata;
  logic [W-1:0]         wr_l [ALL_LANES];
  logic [W-1:0]         rd_l [ALL_LANES];
  logic [TAP_NUM*W-1:0] taps_n;
  logic [W-1:0]         tail_n;
  grp_mode_e            grp;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign grp      = (split_i && !tail_en_i) ? GRP_SPLIT : GRP_CHAIN;

  lds_ptr #(.MAX_LEN(MAX_LEN), .AW(AW), .LW(LW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .step_i(accept), .hres_i(hres_i),
    .len_i(len_i), .addr_o(addr)
  );

  lds_ram #(.DW(DW), .DEPTH(MAX_LEN), .AW(AW)) u_ram (
    .clk(clk), .we_i(accept), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  lds_hdly #(.DEPTH(HDLY_DEPTH), .SW(HS_W)) u_hdly (
    .clk(clk), .rst_n(rst_n), .hres_i(hres_i), .sel_i(hdly_sel_i),
    .hres_dly_o(hres_dly_o)
  );

  // lane routing: chain inside each group, group B head selectable
  for (genvar j = 0; j < ALL_LANES; j++) begin : g_lane
    if (j == 0) begin : g_head_a
      assign wr_l[j] = pix_a;
    end else if (j == 1) begin : g_byp
      assign wr_l[j] = bypass_i ? pix_a : rd_l[0];
    end else if (j == GRP_LANES) begin : g_head_b
      assign wr_l[j] = (grp == GRP_SPLIT) ? pix_b : rd_l[j-1];
    end else begin : g_chain
      assign wr_l[j] = rd_l[j-1];
    end
    assign wdata[j*W +: W] = wr_l[j];
    assign rd_l[j]         = rdata[j*W +: W];
  end

  // tap vector: current pixel, then every delay output
  assign taps_n[0 +: W] = pix_a;
  for (genvar k = 1; k < TAP_NUM; k++) begin : g_tap
    if (k == 1) begin : g_t1
      assign taps_n[k*W +: W] = bypass_i ? pix_a : rd_l[0];
    end else if (k > GRP_LANES) begin : g_tb
      assign taps_n[k*W +: W] = four_i ? '0 : rd_l[k-1];
    end else begin : g_ta
      assign taps_n[k*W +: W] = rd_l[k-1];
    end
  end

  assign tail_n = !tail_en_i ? '0 :
                  (four_i ? rd_l[GRP_LANES-1] : rd_l[ALL_LANES-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      taps_o    <= '0;
      tail_o    <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      taps_o    <= taps_n;
      tail_o    <= tail_n;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(taps_o) && $stable(tail_o)));

  // R2
  tap0_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_valid && taps_o[0 +: W] == $past(pix_a)));

  // R4
  bypass_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bypass_i) |=> (taps_o[W +: W] == taps_o[0 +: W]));

  // R8
  four_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && four_i) |=> (taps_o[TAP_NUM*W-1 -: GRP_LANES*W] == '0));

  // R9
  tail_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !tail_en_i) |=> (tail_o == '0));
endmodule

// File: tb/line_delay_store_tb.sv
module line_delay_store_tb;
  localparam int W   = 8;
  localparam int MAX = 1024;
  localparam int LW  = 11;
  localparam int NT  = 9;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 0;
  logic [W-1:0] pix_a = 0, pix_b = 0, tail_o;
  logic hres_i = 0, bypass_i = 0, split_i = 0, four_i = 0, tail_en_i = 0;
  logic [LW-1:0] len_i = 11'd4;
  logic [3:0] hdly_sel_i = 0;
  logic [NT*W-1:0] taps_o;
  logic hres_dly_o;

  always #5 clk = ~clk;

  line_delay_store u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .pix_a(pix_a), .pix_b(pix_b), .hres_i(hres_i), .bypass_i(bypass_i),
    .split_i(split_i), .four_i(four_i), .tail_en_i(tail_en_i), .len_i(len_i),
    .hdly_sel_i(hdly_sel_i), .out_valid(out_valid), .out_ready(out_ready),
    .taps_o(taps_o), .tail_o(tail_o), .hres_dly_o(hres_dly_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  // bench model state
  logic [W-1:0] ha [0:9999];
  logic [W-1:0] hb [0:9999];
  int n = 0, segL = 1;
  bit m_byp, m_split, m_four, m_tail;

  logic [NT*W-1:0] exp_q [$];
  logic [NT-1:0]   msk_q [$];
  logic [W:0]      tl_q  [$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // value of a line source at depth d, with known flag in bit W
  function automatic logic [W:0] pick(input bit src_b, input int d);
    int idx = n - d * segL;
    if (idx < 0) return '0;
    return {1'b1, src_b ? hb[idx] : ha[idx]};
  endfunction

  function automatic int dep_a(input int j);
    return (m_byp && j >= 1) ? j : j + 1;
  endfunction

  task automatic push_exp();
    logic [NT*W-1:0] e = '0;
    logic [NT-1:0] m = '0;
    logic [W:0] v, lane [8];
    bit chained = !(m_split && !m_tail);
    for (int j = 0; j < 4; j++) lane[j] = pick(1'b0, dep_a(j));
    for (int j = 0; j < 4; j++)
      lane[4+j] = chained ? pick(1'b0, dep_a(3) + j + 1) : pick(1'b1, j + 1);
    e[0 +: W] = ha[n]; m[0] = 1'b1;
    for (int k = 1; k < NT; k++) begin
      if (k == 1 && m_byp) v = {1'b1, ha[n]};
      else if (k > 4 && m_four) v = {1'b1, {W{1'b0}}};
      else v = lane[k-1];
      e[k*W +: W] = v[W-1:0];
      m[k] = v[W];
    end
    exp_q.push_back(e);
    msk_q.push_back(m);
    if (!m_tail) tl_q.push_back({1'b1, {W{1'b0}}});
    else tl_q.push_back(m_four ? lane[3] : lane[7]);
  endtask

  task automatic check_out();
    logic [NT*W-1:0] e, mm;
    logic [NT-1:0] m;
    logic [W:0] t;
    if (exp_q.size() == 0) begin
      check(1'b0, "R1", "unexpected output beat", 0, 0);
      return;
    end
    e = exp_q.pop_front(); m = msk_q.pop_front(); t = tl_q.pop_front();
    for (int k = 0; k < NT; k++) mm[k*W +: W] = {W{m[k]}};
    check((taps_o & mm) == (e & mm), cur_req, "taps", taps_o & mm, e & mm);
    if (t[W]) check(tail_o == t[W-1:0], "R9", "tail", tail_o, t[W-1:0]);
  endtask

  task automatic idle_cycle(input bit force_rdy);
    @(negedge clk);
    out_ready = force_rdy ? 1'b1 : (($urandom % 4) != 0);
    in_valid = 0; hres_i = 0;
    #1;
    if (out_valid && out_ready) check_out();
  endtask

  task automatic drive_beat(input logic [W-1:0] a, input logic [W-1:0] b, input logic h);
    bit got = 0;
    while (!got) begin
      @(negedge clk);
      out_ready = ($urandom % 4) != 0;
      in_valid = 1; pix_a = a; pix_b = b; hres_i = h;
      #1;
      if (out_valid && out_ready) check_out();
      if (in_ready) got = 1;
    end
  endtask

  task automatic drain();
    repeat (4) idle_cycle(1'b1);
    check(exp_q.size() == 0, "R1", "queue drained", exp_q.size(), 0);
  endtask

  // one segment: restart beat then nb beats; optional len change without restart
  task automatic run_seg(input int L, input bit byp, input bit spl, input bit fr,
                         input bit tl, input int nb, input int chg_at,
                         input int chg_len, input string req);
    logic [W-1:0] a, b;
    cur_req = req;
    bypass_i = byp; split_i = spl; four_i = fr; tail_en_i = tl;
    m_byp = byp; m_split = spl; m_four = fr; m_tail = tl;
    len_i = LW'(L); segL = L;
    for (int i = 0; i < nb; i++) begin
      if (i == chg_at) len_i = LW'(chg_len);
      if (($urandom % 6) == 0) idle_cycle(1'b0);
      a = W'($urandom); b = W'($urandom);
      drive_beat(a, b, (i == 0));
      n = i; ha[i] = a; hb[i] = b;
      push_exp();
    end
    drain();
  endtask

  task automatic hdly_test(input int s);
    hdly_sel_i = 4'(s);
    in_valid = 0;
    repeat (20) @(negedge clk);
    @(negedge clk); hres_i = 1;
    for (int c = 1; c <= 18; c++) begin
      @(negedge clk);
      if (c == 1) hres_i = 0;
      #1;
      check(hres_dly_o == (c == s + 1), "R10", "hres delay", hres_dly_o, (c == s + 1));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check(out_valid == 0, "R1", "out_valid at reset", out_valid, 0);
    check(in_ready == 1, "R1", "in_ready at reset", in_ready, 1);
    check(hres_dly_o == 0, "R10", "hres_dly at reset", hres_dly_o, 0);
    @(negedge clk); rst_n = 1;

    run_seg(5, 0, 0, 0, 0, 60, -1, 0, "R3");
    run_seg(3, 1, 0, 0, 0, 50, -1, 0, "R4");
    run_seg(4, 0, 1, 0, 0, 40, -1, 0, "R7");
    run_seg(6, 0, 0, 1, 1, 50, -1, 0, "R8");
    run_seg(4, 0, 1, 0, 1, 50, -1, 0, "R9");
    run_seg(1, 0, 0, 0, 0, 30, -1, 0, "R11");
    run_seg(5, 0, 0, 0, 0, 70, 15, 2, "R6");
    run_seg(2, 0, 0, 0, 0, 30, -1, 0, "R5");
    run_seg(7, 1, 1, 0, 0, 60, -1, 0, "R2");
    run_seg(MAX, 0, 0, 0, 0, 8300, -1, 0, "R11");

    // R1 directed stall
    @(negedge clk);
    out_ready = 0; in_valid = 1; pix_a = 8'hA5; hres_i = 0;
    #1;
    check(in_ready == 1, "R1", "ready when empty", in_ready, 1);
    @(negedge clk);
    in_valid = 0;
    #1;
    held = taps_o[7:0];
    check(held == 8'hA5, "R1", "stalled tap0", held, 8'hA5);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      check(out_valid == 1 && in_ready == 0 && taps_o[7:0] == held,
            "R1", "held under stall", {out_valid, in_ready, taps_o[7:0]}, {2'b10, held});
    end
    @(negedge clk); out_ready = 1;
    @(negedge clk);
    #1;
    check(out_valid == 0, "R1", "valid falls after drain", out_valid, 0);

    hdly_test(0);
    hdly_test(3);
    hdly_test(15);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule